// File: doc/BRIEF.md
# Hierarchical Round-Robin Switch Arbiter

This block picks one of M requesting input queues for a single output port of a crossbar. It is built as a tree of small round-robin cells. Each cell keeps its own one-hot token and sends the OR of its request lines to the level above. Each cell also gates its local choice with the acknowledge that comes back down. The single cell at the top of the tree is enabled by its own combined request, and its local grants serve as the acknowledges for its children. The grant is a combinational function of the current requests and the registered tokens, so it is valid in the same cycle as the request.

The tree is laid out from 4-input cells wherever possible, because they keep the number of levels small. Request lines are grouped four at a time by index, so lines 4c to 4c+3 share a cell. A leftover group of three uses a 4-input cell with one spare input. A leftover group of one or two uses a 2-input cell. The grouping repeats level by level until one cell remains. For M = 32 this gives eight 4-input cells, then two 4-input cells, then a 2-input top cell. For M = 8 it gives two 4-input cells under a 2-input top cell.

Top module: `rr_tree_arb`

## Requirements
- R1: Synchronous reset (`rst` high) puts every cell token on its local line 0. In the first cycle after reset with all lines requesting, the grant is line 0.
- R2: `grant` has at most one bit set. It is zero when `req` is zero, and it is nonzero whenever any `req` bit is set.
- R3: A `grant` bit is only ever set for a line whose `req` bit is set in the same cycle.
- R4: The grant follows `req` combinationally in the same cycle. A single requesting line is always granted at once.
- R5: A cell's token is one-hot. It moves up by one position, modulo the cell width, at a clock edge only when that cell granted with its parent acknowledge high. Otherwise it holds. Cycles with no request leave all tokens unchanged.
- R6: Within a cell, the winner is the first requesting child found by scanning upward from the token position, with wrap-around. A child requests when any line below it requests.
- R7: When M is a power of two, a line that keeps requesting is granted within M consecutive cycles. With every line requesting from reset, M cycles grant each line exactly once.
- R8: Tree layout uses groups of four consecutive indices. The final pair of nodes uses a 2-input top cell. For M = 32 with all lines requesting from reset, cycle t grants line 16·(t mod 2) + 4·(⌊t/2⌋ mod 4) + (⌊t/8⌋ mod 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | M | Request from each input queue |
| grant | output | M | One-hot grant, combinational from `req` and tokens |

## Verification
Grants are due in the same cycle as the request pattern that causes them. The bench drives `req` on the falling edge and compares `grant` 1 ns later. Token movement becomes visible only through the grant of the next pattern, after the rising edge in between. The bench's arithmetic model of the M = 8 tree therefore advances its own tokens once per driven pattern, and the reset effect is checked on the first pattern after `rst` falls. The M = 32 order check uses the closed-form index from R8, one cycle per entry.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

  // Node count at tree level l (level 0 holds the M request lines).
  function automatic int lvl_nodes(input int m, input int l);
    int n;
    n = m;
    for (int i = 0; i < l; i++) n = (n + 3) / 4;
    return n;
  endfunction

  // Number of cell levels above the request lines.
  function automatic int tree_levels(input int m);
    int n;
    int l;
    n = m;
    l = 0;
    while (n > 1) begin
      n = (n + 3) / 4;
      l++;
    end
    return l;
  endfunction

  // Offset of level l inside the flat node vector.
  function automatic int node_base(input int m, input int l);
    int s;
    s = 0;
    for (int i = 0; i < l; i++) s += lvl_nodes(m, i);
    return s;
  endfunction

  function automatic int tree_nodes(input int m);
    return node_base(m, tree_levels(m) + 1);
  endfunction

  // Offset of the first cell of level l (cells of level l feed nodes of level l+1).
  function automatic int cell_base(input int m, input int l);
    return node_base(m, l + 1) - m;
  endfunction

  // Lines actually used by cell c of a level with n inputs.
  function automatic int cell_used(input int n, input int c);
    return ((n - 4 * c) >= 4) ? 4 : (n - 4 * c);
  endfunction

  function automatic int cell_width(input int used);
    return (used >= 3) ? 4 : 2;
  endfunction

  // Worst-case wait window: product of widest cell per level.
  function automatic int fair_bound(input int m);
    int p;
    p = 1;
    for (int l = 0; l < tree_levels(m); l++)
      p = p * ((lvl_nodes(m, l) >= 3) ? 4 : 2);
    return p;
  endfunction

  // First requesting line at or after the token position, cyclic over w lines.
  function automatic logic [3:0] rr_pick(input logic [3:0] rq, input logic [3:0] tok,
                                         input int w);
    logic [3:0] g;
    logic       hit;
    int         s;
    int         j;
    g   = '0;
    hit = 1'b0;
    s   = 0;
    for (int k = 0; k < 4; k++) if (tok[k]) s = k;
    for (int k = 0; k < 4; k++) begin
      j = s + k;
      if (j >= w) j = j - w;
      if ((k < w) && !hit && (j < 4) && rq[j]) begin
        g[j] = 1'b1;
        hit  = 1'b1;
      end
    end
    return g;
  endfunction

  // Ring advance of a one-hot token over w positions.
  function automatic logic [3:0] rr_next(input logic [3:0] tok, input int w);
    return (w == 4) ? {tok[2:0], tok[3]} : {2'b00, tok[0], tok[1]};
  endfunction

endpackage

// File: rtl/rr_tree_pick.sv
module rr_tree_pick
  import rrt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] rq,
  input  logic [3:0]   tok,
  output logic [W-1:0] pick
);

  logic [3:0] full;

  assign full = rr_pick(4'(rq), tok, W);
  assign pick = full[W-1:0];

  if (W < 4) begin : g_pad
    logic unused_hi;
    assign unused_hi = ^full[3:W];
  end

endmodule

// File: rtl/rr_tree_cell.sv
module rr_tree_cell
  import rrt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lreq,
  input  logic         ack,
  output logic         up_req,
  output logic [W-1:0] lgnt,
  output logic         fire,
  output logic [3:0]   tok_o
);

  logic [3:0]   tok_q;
  logic [W-1:0] pick;

  rr_tree_pick #(.W(W)) u_pick (
    .rq  (lreq),
    .tok (tok_q),
    .pick(pick)
  );

  assign up_req = |lreq;
  assign lgnt   = pick & {W{ack}};
  assign fire   = ack & up_req;
  assign tok_o  = tok_q;

  always_ff @(posedge clk) begin
    if (rst)       tok_q <= 4'b0001;
    else if (fire) tok_q <= rr_next(tok_q, W);
  end

endmodule

// File: rtl/rr_tree_arb.sv
module rr_tree_arb
  import rrt_pkg::*;
#(
  parameter int M = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [M-1:0] req,
  output logic [M-1:0] grant
);

  localparam int NLEV  = tree_levels(M);
  localparam int NTOT  = tree_nodes(M);
  localparam int NCELL = NTOT - M;

  logic [NTOT-1:0]    nd_req;
  logic [NTOT-1:0]    nd_ack;
  logic [NCELL-1:0]   cell_fire;
  logic [NCELL*4-1:0] cell_tok;

  assign nd_req[M-1:0] = req;
  assign grant         = nd_ack[M-1:0];
  // Top cell is enabled by its own combined request.
  assign nd_ack[NTOT-1] = nd_req[NTOT-1];

  for (genvar l = 0; l < NLEV; l++) begin : g_lvl
    localparam int NIN  = lvl_nodes(M, l);
    localparam int NOUT = lvl_nodes(M, l + 1);
    localparam int IB   = node_base(M, l);
    localparam int OB   = node_base(M, l + 1);
    localparam int CB   = cell_base(M, l);
    for (genvar c = 0; c < NOUT; c++) begin : g_cell
      localparam int USED = cell_used(NIN, c);
      localparam int W    = cell_width(USED);
      logic [W-1:0] crq;
      logic [W-1:0] cgn;

      if (USED == W) begin : g_full
        assign crq = nd_req[IB + 4*c +: W];
      end else begin : g_part
        assign crq = W'(nd_req[IB + 4*c +: USED]);
        logic unused_spare;
        assign unused_spare = ^cgn[W-1:USED];
      end

      rr_tree_cell #(.W(W)) u_cell (
        .clk   (clk),
        .rst   (rst),
        .lreq  (crq),
        .ack   (nd_ack[OB + c]),
        .up_req(nd_req[OB + c]),
        .lgnt  (cgn),
        .fire  (cell_fire[CB + c]),
        .tok_o (cell_tok[(CB + c)*4 +: 4])
      );

      assign nd_ack[IB + 4*c +: USED] = cgn[USED-1:0];
    end
  end

endmodule

// File: rtl/rr_tree_arb_chk.sv
module rr_tree_arb_chk
  import rrt_pkg::*;
#(
  parameter int M = 32
) (
  input logic                            clk,
  input logic                            rst,
  input logic [M-1:0]                    req,
  input logic [M-1:0]                    grant,
  input logic [tree_nodes(M)-M-1:0]      cell_fire,
  input logic [(tree_nodes(M)-M)*4-1:0]  cell_tok
);

  localparam int NCELL = tree_nodes(M) - M;
  localparam int FB    = fair_bound(M);
  localparam int CW    = $clog2(FB + 1) + 1;

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> (|grant));

  p_active_r3: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req) == '0);

  p_start_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && req[0]) |-> grant[0]);

  for (genvar c = 0; c < NCELL; c++) begin : g_cellchk
    p_tok_onehot_r5: assert property (@(posedge clk) disable iff (rst)
      $onehot(cell_tok[c*4 +: 4]));
    p_tok_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !cell_fire[c] |=> $stable(cell_tok[c*4 +: 4]));
    p_tok_move_r5: assert property (@(posedge clk) disable iff (rst)
      cell_fire[c] |=> !$stable(cell_tok[c*4 +: 4]));
  end

  for (genvar i = 0; i < M; i++) begin : g_fair
    logic [CW-1:0] wait_q;
    always_ff @(posedge clk) begin
      if (rst || !req[i] || grant[i]) wait_q <= '0;
      else                            wait_q <= wait_q + 1'b1;
    end
    p_fair_r7: assert property (@(posedge clk) disable iff (rst)
      wait_q < CW'(FB));
  end

endmodule

bind rr_tree_arb rr_tree_arb_chk #(.M(M)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req      (req),
  .grant    (grant),
  .cell_fire(cell_fire),
  .cell_tok (cell_tok)
);

// File: tb/rr_tree_arb_bench.sv
`timescale 1ns/1ps
module rr_tree_arb_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  req8 = '0;
  logic [7:0]  grant8;
  logic [31:0] req32 = '0;
  logic [31:0] grant32;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // model state for the 8-line tree (two 4-wide cells under a 2-wide top)
  int rt;
  int lt [2];

  always #5 clk = ~clk;

  rr_tree_arb #(.M(8)) u_rr_tree_arb (
    .clk(clk), .rst(rst), .req(req8), .grant(grant8)
  );

  rr_tree_arb #(.M(32)) u_rr_tree_arb_32 (
    .clk(clk), .rst(rst), .req(req32), .grant(grant32)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst   = 1'b1;
    req8  = '0;
    req32 = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    rt  = 0;
    lt[0] = 0;
    lt[1] = 0;
  endtask

  task automatic step8(input logic [7:0] pat, input string tag);
    logic [7:0] exp;
    logic [1:0] grp_req;
    int grp;
    int ln;
    @(negedge clk);
    req8 = pat;
    #1;
    exp = '0;
    grp = -1;
    ln  = -1;
    grp_req = {|pat[7:4], |pat[3:0]};
    for (int k = 0; k < 2; k++)
      if (grp < 0 && grp_req[(rt + k) % 2]) grp = (rt + k) % 2;
    if (grp >= 0) begin
      for (int k = 0; k < 4; k++)
        if (ln < 0 && pat[4*grp + ((lt[grp] + k) % 4)]) ln = (lt[grp] + k) % 4;
      exp[4*grp + ln] = 1'b1;
      rt      = (rt + 1) % 2;
      lt[grp] = (lt[grp] + 1) % 4;
    end
    chk(tag, 64'(grant8), 64'(exp));
    chk("R2", 64'($countones(grant8) <= 1), 64'd1);
    chk("R3", 64'((grant8 & ~pat) == 8'h00), 64'd1);
  endtask

  initial begin
    int waitc;
    int maxwait;
    logic [31:0] seen;
    int idx;

    do_reset();
    #1;
    chk("R1", 64'(grant8), 64'd0);
    chk("R1", 64'(grant32), 64'd0);
    step8(8'hFF, "R1");
    if (grant8 !== 8'h01) $display("FAIL R1 first grant got=%0h exp=1", grant8);

    // R5: idle cycles leave tokens in place
    step8(8'hFF, "R5");
    for (int k = 0; k < 3; k++) step8(8'h00, "R5");
    step8(8'hFF, "R5");
    chk("R5", 64'(grant8), 64'h02);

    // R4: same-cycle response
    step8(8'h80, "R4");
    chk("R4", 64'(grant8), 64'h80);

    // R8: grouping by four consecutive indices
    do_reset();
    step8(8'h12, "R8");
    chk("R8", 64'(grant8), 64'h02);
    do_reset();
    step8(8'hA0, "R1");
    chk("R1", 64'(grant8), 64'h20);

    // R6: sweep of every request pattern, several orders
    do_reset();
    for (int rep = 0; rep < 3; rep++)
      for (int p = 0; p < 256; p++)
        step8(8'((p * (2*rep + 1)) & 255), "R6");

    // R7: line 3 keeps requesting amid changing traffic
    do_reset();
    waitc = 0;
    maxwait = 0;
    for (int t = 0; t < 64; t++) begin
      step8(8'h08 | 8'((t * 29) & 8'hF7), "R6");
      if (grant8[3]) waitc = 0;
      else begin
        waitc++;
        if (waitc > maxwait) maxwait = waitc;
      end
    end
    chk("R7", 64'(maxwait < 8), 64'd1);

    // 32-line tree: single requests are served at once
    do_reset();
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      req32 = 32'd1 << i;
      #1;
      chk("R4", 64'(grant32), 64'(32'd1 << i));
    end

    // 32-line tree: full-load order and coverage
    do_reset();
    seen = '0;
    for (int t = 0; t < 32; t++) begin
      @(negedge clk);
      req32 = '1;
      #1;
      idx = 16*(t % 2) + 4*((t / 2) % 4) + ((t / 8) % 4);
      chk("R8", 64'(grant32), 64'(32'd1 << idx));
      seen = seen | grant32;
    end
    chk("R7", 64'(seen), 64'hFFFF_FFFF);
    @(negedge clk);
    req32 = '0;
    #1;
    chk("R2", 64'(grant32), 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule